// File: doc/BRIEF.md
# Extended-Dividend Integer Divider

This block is the multi-cycle divide unit of a 64-bit integer core. It forms a double-width dividend by placing the Y register word above the low word of the first operand, and it divides that value by the low word of the second operand. The second operand may come from a register or an immediate; the core supplies it already extended to 64 bits. Both unsigned and signed (two's complement) division are supported, and the signed quotient rounds toward zero.

The quotient goes out as a 64-bit value. When it cannot be held in 32 bits, it is clamped to a fixed saturation value instead of being truncated. When the condition-code variant is requested, the unit also updates two 4-bit flag groups: one for the 32-bit view of the result and one for the 64-bit view. The 32-bit overflow flag reports whether clamping took place. A zero divisor is reported as a fault and leaves the result untouched.

The core pulses `start` with the operands valid. Inside, one shift-subtract step runs per clock on magnitudes. The unit then pulses `done` and holds the result until the next operation completes.

Top module: `xdiv_unit`

## Requirements
- R1: The dividend is {y_val[31:0], src_a[31:0]} and the divisor is src_b[31:0]; bits 63:32 of src_a and src_b have no effect on any output.
- R2: In unsigned mode (is_signed=0), a quotient below 2^32 is returned zero-extended to 64 bits, including the boundary value 0x00000000FFFFFFFF.
- R3: In unsigned mode, a quotient of 2^32 or more returns 0x00000000FFFFFFFF.
- R4: In signed mode (is_signed=1), dividend and divisor are two's complement, the quotient truncates toward zero, and an in-range quotient is returned sign-extended to 64 bits.
- R5: In signed mode, a quotient above 2^31-1 returns 0x000000007FFFFFFF. This includes the most negative dividend divided by -1.
- R6: In signed mode, a quotient below -2^31 returns 0xFFFFFFFF80000000, and a quotient of exactly -2^31 returns the same value without clamping.
- R7: A start whose divisor low word is zero gives done and div_zero=1 one cycle later. Result and flags are left unchanged. The next operation that completes normally clears div_zero.
- R8: With cc_en=1, a completing divide writes icc and xcc, each laid out as {N,Z,V,C} in bits [3:0]. icc.N is result[31] and icc.Z is (result[31:0]==0). icc.V is 1 exactly when clamping occurred. xcc.N is result[63] and xcc.Z is (result==0). icc.C, xcc.C and xcc.V are 0.
- R9: With cc_en=0, icc and xcc keep their previous values.
- R10: For a nonzero divisor, done rises on the 65th rising edge after the edge that samples start, and stays high for exactly one cycle.
- R11: A start raised while an operation is in progress is ignored: it neither alters that operation's result nor produces an extra done. The result changes only in the cycle that done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a divide with the current inputs (only when idle) |
| is_signed | input | 1 | 1 = signed division, 0 = unsigned |
| cc_en | input | 1 | 1 = update the condition flags on completion |
| src_a | input | 64 | First operand; low word is the dividend's low half |
| src_b | input | 64 | Second operand; low word is the divisor |
| y_val | input | 32 | Y register; the dividend's high half |
| result | output | 64 | Clamped, extended quotient |
| div_zero | output | 1 | Last completed operation had a zero divisor |
| icc | output | 4 | 32-bit flags {N,Z,V,C} |
| xcc | output | 4 | 64-bit flags {N,Z,V,C} |
| done | output | 1 | One-cycle completion strobe |

## Verification
The hardest situations to reach are the edges of the clamp windows in signed mode. These are a quotient of exactly -2^31 against one of -2^31-1, a quotient of exactly 2^31-1 against 2^31, and the most negative 64-bit dividend divided by -1, whose magnitude only fits after negation. Each of these is built directly by choosing the Y word and the operand low word so the dividend sits one step on either side of the limit. The ignored start is reached by raising a second start partway through a running divide, then checking both the first operation's quotient and that no second done follows.

// File: rtl/xdiv_pkg.sv
package xdiv_pkg;

    typedef enum logic [1:0] {
        XD_IDLE = 2'd0,
        XD_RUN  = 2'd1,
        XD_FIN  = 2'd2
    } xd_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } xd_flags_t;

endpackage

// File: rtl/xdiv_prep.sv
// Forms the double-width dividend and converts both operands to magnitudes.
module xdiv_prep #(
    parameter int DW = 32
) (
    input  logic              is_signed,
    input  logic [DW-1:0]     y_word,
    input  logic [DW-1:0]     a_word,
    input  logic [DW-1:0]     b_word,
    output logic [2*DW-1:0]   dvd_mag,
    output logic [DW-1:0]     dvs_mag,
    output logic              q_neg,
    output logic              dvs_zero
);
    localparam int W = 2 * DW;

    logic [W-1:0] dvd_raw;
    logic         dvd_neg;
    logic         dvs_neg;

    always_comb begin
        dvd_raw  = {y_word, a_word};
        dvd_neg  = is_signed & dvd_raw[W-1];
        dvs_neg  = is_signed & b_word[DW-1];
        dvd_mag  = dvd_neg ? (~dvd_raw + W'(1)) : dvd_raw;
        dvs_mag  = dvs_neg ? (~b_word + DW'(1)) : b_word;
        q_neg    = dvd_neg ^ dvs_neg;
        dvs_zero = (b_word == '0);
    end
endmodule

// File: rtl/xdiv_step.sv
// One restoring shift-subtract iteration.
module xdiv_step #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]   rem_i,
    input  logic [2*DW-1:0] quo_i,
    input  logic [DW-1:0]   dvs_i,
    output logic [DW-1:0]   rem_o,
    output logic [2*DW-1:0] quo_o
);
    localparam int W = 2 * DW;

    logic [DW:0]   shifted;
    logic [DW+1:0] trial;
    logic          fits;

    always_comb begin
        shifted = {rem_i, quo_i[W-1]};
        trial   = {1'b0, shifted} - {2'b00, dvs_i};
        fits    = ~trial[DW+1];
        rem_o   = fits ? trial[DW-1:0] : shifted[DW-1:0];
        quo_o   = {quo_i[W-2:0], fits};
    end
endmodule

// File: rtl/xdiv_post.sv
// Applies the quotient sign and clamps out-of-range values.
module xdiv_post #(
    parameter int DW = 32
) (
    input  logic [2*DW-1:0] mag,
    input  logic            q_neg,
    input  logic            is_signed,
    output logic [2*DW-1:0] res,
    output logic            clamped
);
    localparam int           W       = 2 * DW;
    localparam logic [W-1:0] U_MAX   = {{DW{1'b0}}, {DW{1'b1}}};
    localparam logic [W-1:0] S_MAX   = {{(DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic [W-1:0] S_MIN   = {{(DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic [W-1:0] NEG_LIM = W'(1) << (DW - 1);

    always_comb begin
        res     = mag;
        clamped = 1'b0;
        if (!is_signed) begin
            if (|mag[W-1:DW]) begin
                res     = U_MAX;
                clamped = 1'b1;
            end
        end else if (!q_neg) begin
            if (|mag[W-1:DW-1]) begin
                res     = S_MAX;
                clamped = 1'b1;
            end
        end else begin
            if (mag > NEG_LIM) begin
                res     = S_MIN;
                clamped = 1'b1;
            end else begin
                res = ~mag + W'(1);
            end
        end
    end
endmodule

// File: rtl/xdiv_unit.sv
module xdiv_unit
    import xdiv_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_signed,
    input  logic              cc_en,
    input  logic [2*DW-1:0]   src_a,
    input  logic [2*DW-1:0]   src_b,
    input  logic [DW-1:0]     y_val,
    output logic [2*DW-1:0]   result,
    output logic              div_zero,
    output logic [3:0]        icc,
    output logic [3:0]        xcc,
    output logic              done
);
    localparam int W  = 2 * DW;
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        xd_state_e      st;
        logic [CW-1:0]  cnt;
        logic [DW-1:0]  rem;
        logic [W-1:0]   quo;
        logic [DW-1:0]  dvs;
        logic           neg;
        logic           sgn;
        logic           cc;
        logic [W-1:0]   res;
        logic           dz;
        logic           done;
        xd_flags_t      icc;
        xd_flags_t      xcc;
    } regs_t;

    regs_t r_d, r_q;

    logic [W-1:0]  p_dvd_mag;
    logic [DW-1:0] p_dvs_mag;
    logic          p_q_neg;
    logic          p_dvs_zero;
    logic [DW-1:0] s_rem;
    logic [W-1:0]  s_quo;
    logic [W-1:0]  f_res;
    logic          f_clamped;
    logic          unused_upper;

    assign unused_upper = ^{src_a[W-1:DW], src_b[W-1:DW]};

    xdiv_prep #(.DW(DW)) u_prep (
        .is_signed (is_signed),
        .y_word    (y_val),
        .a_word    (src_a[DW-1:0]),
        .b_word    (src_b[DW-1:0]),
        .dvd_mag   (p_dvd_mag),
        .dvs_mag   (p_dvs_mag),
        .q_neg     (p_q_neg),
        .dvs_zero  (p_dvs_zero)
    );

    xdiv_step #(.DW(DW)) u_step (
        .rem_i (r_q.rem),
        .quo_i (r_q.quo),
        .dvs_i (r_q.dvs),
        .rem_o (s_rem),
        .quo_o (s_quo)
    );

    xdiv_post #(.DW(DW)) u_post (
        .mag       (r_q.quo),
        .q_neg     (r_q.neg),
        .is_signed (r_q.sgn),
        .res       (f_res),
        .clamped   (f_clamped)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            XD_IDLE: begin
                if (start) begin
                    if (p_dvs_zero) begin
                        r_d.done = 1'b1;
                        r_d.dz   = 1'b1;
                    end else begin
                        r_d.st  = XD_RUN;
                        r_d.cnt = CW'(W);
                        r_d.rem = '0;
                        r_d.quo = p_dvd_mag;
                        r_d.dvs = p_dvs_mag;
                        r_d.neg = p_q_neg;
                        r_d.sgn = is_signed;
                        r_d.cc  = cc_en;
                    end
                end
            end
            XD_RUN: begin
                r_d.rem = s_rem;
                r_d.quo = s_quo;
                r_d.cnt = r_q.cnt - CW'(1);
                if (r_q.cnt == CW'(1)) begin
                    r_d.st = XD_FIN;
                end
            end
            XD_FIN: begin
                r_d.st   = XD_IDLE;
                r_d.res  = f_res;
                r_d.dz   = 1'b0;
                r_d.done = 1'b1;
                if (r_q.cc) begin
                    r_d.icc.n = f_res[DW-1];
                    r_d.icc.z = (f_res[DW-1:0] == '0);
                    r_d.icc.v = f_clamped;
                    r_d.icc.c = 1'b0;
                    r_d.xcc.n = f_res[W-1];
                    r_d.xcc.z = (f_res == '0);
                    r_d.xcc.v = 1'b0;
                    r_d.xcc.c = 1'b0;
                end
            end
            default: r_d.st = XD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign result   = r_q.res;
    assign div_zero = r_q.dz;
    assign icc      = r_q.icc;
    assign xcc      = r_q.xcc;
    assign done     = r_q.done;

    // R10: completion strobe lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);

    // R11: result moves only together with done
    a_r11_res_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.res) |-> r_q.done);

    // R11: a start during a running divide does not reload the divisor
    a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != XD_IDLE && start) |=> $stable(r_q.dvs));

    // R7: zero-divisor completion leaves result untouched
    a_r7_dz_keeps_res: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.done && r_q.dz) |-> $stable(r_q.res));

    // R3: unsigned results never exceed 32 bits
    a_r3_unsigned_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.done && !r_q.dz && !r_q.sgn) |-> (r_q.res[W-1:DW] == '0));

    // R5: non-negative signed results stay at or below 2^31-1
    a_r5_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.done && !r_q.dz && r_q.sgn && !r_q.res[W-1]) |-> (r_q.res[W-1:DW-1] == '0));

    // R6: negative signed results stay at or above -2^31
    a_r6_neg_range: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.done && !r_q.dz && r_q.sgn && r_q.res[W-1]) |-> (&r_q.res[W-1:DW-1]));

    // R8: carry flags and 64-bit overflow are clear after a cc divide
    a_r8_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.done && !r_q.dz && r_q.cc) |-> (!r_q.icc.c && !r_q.xcc.c && !r_q.xcc.v));

    // R9: flags change only on a completion that requested them
    a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(r_q.icc) || !$stable(r_q.xcc)) |-> (r_q.done && !r_q.dz && r_q.cc));
endmodule

// File: tb/test_xdiv_unit.sv
module test_xdiv_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic        cc_en = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [31:0] y_val = '0;
    logic [63:0] result;
    logic        div_zero;
    logic [3:0]  icc;
    logic [3:0]  xcc;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    xdiv_unit i_xdiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .cc_en(cc_en), .src_a(src_a), .src_b(src_b), .y_val(y_val),
        .result(result), .div_zero(div_zero), .icc(icc), .xcc(xcc), .done(done)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Issue one divide; lat = negedge count after start at which done is seen.
    task automatic go(input logic sg, input logic cc, input logic [63:0] a,
                      input logic [63:0] b, input logic [31:0] y, output int lat);
        @(negedge clk);
        is_signed = sg; cc_en = cc; src_a = a; src_b = b; y_val = y;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic do_case(input string tag, input logic sg, input logic cc,
                           input logic [63:0] a, input logic [63:0] b, input logic [31:0] y,
                           input logic [63:0] exp, input logic [3:0] e_icc, input logic [3:0] e_xcc);
        int lat;
        go(sg, cc, a, b, y, lat);
        chk({tag, " R10 latency"}, 64'(lat), 64'd66);
        chk({tag, " result"}, result, exp);
        chk({tag, " R7 div_zero clear"}, 64'(div_zero), 64'd0);
        chk({tag, " icc"}, 64'(icc), 64'(e_icc));
        chk({tag, " xcc"}, 64'(xcc), 64'(e_xcc));
        @(negedge clk);
        chk({tag, " R10 done one cycle"}, 64'(done), 64'd0);
    endtask

    task automatic t_reset;
        chk("reset result", result, 64'd0);
        chk("reset done", 64'(done), 64'd0);
        chk("reset div_zero", 64'(div_zero), 64'd0);
        chk("reset flags", 64'({icc, xcc}), 64'd0);
    endtask

    task automatic t_unsigned;
        do_case("R1 upper bits ignored", 1'b0, 1'b1, 64'hDEAD_BEEF_0000_0064,
                64'h1234_5678_0000_0007, 32'h0, 64'd14, 4'b0000, 4'b0000);
        do_case("R1 Y forms high half", 1'b0, 1'b1, 64'h0, 64'd2, 32'h1,
                64'h0000_0000_8000_0000, 4'b1000, 4'b0000);
        do_case("R2 boundary no clamp", 1'b0, 1'b1, 64'h0000_0000_FFFF_FFFE, 64'd2, 32'h1,
                64'h0000_0000_FFFF_FFFF, 4'b1000, 4'b0000);
        do_case("R3 exactly 2^32", 1'b0, 1'b1, 64'h0, 64'd2, 32'h2,
                64'h0000_0000_FFFF_FFFF, 4'b1010, 4'b0000);
        do_case("R3 large quotient", 1'b0, 1'b1, 64'h0, 64'd3, 32'h5,
                64'h0000_0000_FFFF_FFFF, 4'b1010, 4'b0000);
    endtask

    task automatic t_signed;
        do_case("R4 neg/pos", 1'b1, 1'b1, 64'h0000_0000_FFFF_FF9C, 64'd7, 32'hFFFF_FFFF,
                64'hFFFF_FFFF_FFFF_FFF2, 4'b1000, 4'b1000);
        do_case("R4 pos/neg", 1'b1, 1'b1, 64'd100, 64'h0000_0000_FFFF_FFF9, 32'h0,
                64'hFFFF_FFFF_FFFF_FFF2, 4'b1000, 4'b1000);
        do_case("R4 neg/neg", 1'b1, 1'b1, 64'h0000_0000_FFFF_FF9C, 64'h0000_0000_FFFF_FFF9,
                32'hFFFF_FFFF, 64'd14, 4'b0000, 4'b0000);
        do_case("R5 2^31 clamps", 1'b1, 1'b1, 64'h0000_0000_8000_0000, 64'd1, 32'h0,
                64'h0000_0000_7FFF_FFFF, 4'b0010, 4'b0000);
        do_case("R5 max no clamp", 1'b1, 1'b1, 64'h0000_0000_7FFF_FFFF, 64'd1, 32'h0,
                64'h0000_0000_7FFF_FFFF, 4'b0000, 4'b0000);
        do_case("R5 min dividend by -1", 1'b1, 1'b1, 64'h0, 64'h0000_0000_FFFF_FFFF,
                32'h8000_0000, 64'h0000_0000_7FFF_FFFF, 4'b0010, 4'b0000);
        do_case("R6 below min clamps", 1'b1, 1'b1, 64'h0000_0000_7FFF_FFFF, 64'd1,
                32'hFFFF_FFFF, 64'hFFFF_FFFF_8000_0000, 4'b1010, 4'b1000);
        do_case("R6 exact min", 1'b1, 1'b1, 64'h0000_0000_8000_0000, 64'd1, 32'hFFFF_FFFF,
                64'hFFFF_FFFF_8000_0000, 4'b1000, 4'b1000);
        do_case("R6 min via neg divisor", 1'b1, 1'b1, 64'h0000_0000_8000_0000,
                64'h0000_0000_FFFF_FFFF, 32'h0, 64'hFFFF_FFFF_8000_0000, 4'b1000, 4'b1000);
    endtask

    task automatic t_flags;
        do_case("R8 zero unsigned", 1'b0, 1'b1, 64'd3, 64'd7, 32'h0,
                64'd0, 4'b0100, 4'b0100);
        do_case("R8 zero signed truncation", 1'b1, 1'b1, 64'h0000_0000_FFFF_FFFD, 64'd7,
                32'hFFFF_FFFF, 64'd0, 4'b0100, 4'b0100);
        do_case("R9 cc off keeps flags", 1'b0, 1'b0, 64'h0, 64'd3, 32'h5,
                64'h0000_0000_FFFF_FFFF, 4'b0100, 4'b0100);
    endtask

    task automatic t_divzero;
        int lat;
        go(1'b0, 1'b1, 64'd55, 64'hFFFF_0000_0000_0000, 32'h0, lat);
        chk("R7 zero divisor latency", 64'(lat), 64'd1);
        chk("R7 div_zero set", 64'(div_zero), 64'd1);
        chk("R7 result unchanged", result, 64'h0000_0000_FFFF_FFFF);
        chk("R7 flags unchanged", 64'({icc, xcc}), 64'h44);
        @(negedge clk);
        chk("R7 R10 done one cycle", 64'(done), 64'd0);
        do_case("R7 next op clears fault", 1'b0, 1'b1, 64'd21, 64'd3, 32'h0,
                64'd7, 4'b0000, 4'b0000);
    endtask

    task automatic t_busy;
        int lat;
        int extra;
        @(negedge clk);
        is_signed = 1'b0; cc_en = 1'b1; src_a = 64'd1000; src_b = 64'd10; y_val = 32'h0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (9) @(negedge clk);
        src_a = 64'd9; src_b = 64'd0; y_val = 32'h1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 11;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk("R11 latency unaffected", 64'(lat), 64'd66);
        chk("R11 first result kept", result, 64'd100);
        chk("R11 no fault from ignored start", 64'(div_zero), 64'd0);
        extra = 0;
        repeat (80) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R11 no extra done", 64'(extra), 64'd0);
        chk("R11 result stable", result, 64'd100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unsigned();
        t_signed();
        t_flags();
        t_divzero();
        t_busy();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got=expired exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule